// File: doc/BRIEF.md
# I2C Target with Clock Stretching

This block is a 7-bit-address I2C target (slave) that runs on a fast system clock and oversamples the SCL and SDA lines. After a START it shifts in an address byte and compares its upper seven bits with a programmable own address. The low bit of that byte selects the direction, which is kept as a status bit. A matching address byte is stored in the receive buffer like any data byte. Unmatched traffic is ignored until the next START.

When the bus writes to the target, each data byte lands in a one-entry receive buffer. A full flag and an overflow flag go with it, and together they decide whether the target acknowledges the byte. When the bus reads from the target, the target stretches SCL low after each acknowledged byte. It keeps SCL low until local logic has written the next transmit byte and then written a release bit. The byte is then shifted out most significant bit first, and SDA changes only while SCL is low.

Local logic reaches the target through a small synchronous register port with three registers:

| Address | Read | Write |
|---|---|---|
| 0 | receive buffer | transmit byte |
| 1 | status | status |
| 2 | own address in bits 6:0 | own address in bits 6:0 |

The status register holds: full (bit 0), overflow (bit 1), direction (bit 2), byte event (bit 3). Bit 4 is the release request; it reads as 0. The byte event is also driven on the `irq` pin. Both bus outputs are pull-low enables for open-drain drivers.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: A START (SDA falling while SCL is high) begins address reception from any state. A STOP (SDA rising while SCL is high) releases both `scl_oe` and `sda_oe`. After reset both enables are 0, `irq` is 0 and the status register reads 0.
- R2: An address byte whose seven upper bits equal the own address and whose last bit is 0 clears the direction bit (status bit 2). It places the whole address byte in the receive buffer, and it is acknowledged on the ninth clock when no overflow condition exists. An address byte that does not match gets no acknowledge, changes no buffer or flag, and makes the target ignore the bus until the next START.
- R3: A matching address byte with last bit 1 sets the direction bit, is placed in the buffer and is always acknowledged. After the ninth clock's falling edge, SCL is held low until a release is accepted. A release is accepted only when the transmit byte (register 0) has been written since the last release and status bit 4 is then written as 1. A release write without a prior transmit write leaves SCL held.
- R4: Transmit data go out most significant bit first. SDA changes only after a falling SCL edge, so it is stable while SCL is high.
- R5: Received bits are sampled on rising SCL edges, MSB first, eight per byte with the acknowledge as the ninth clock. When neither full nor overflow is set, a completed byte is loaded into the buffer, sets full (status bit 0) and is acknowledged.
- R6: A byte that completes while full is set sets overflow (status bit 1). The buffer keeps its old contents and no acknowledge is driven.
- R7: A byte that completes while overflow is 1 and full is 0 is loaded into the buffer and sets full, but is not acknowledged.
- R8: The byte event flag (status bit 3, also on `irq`) is set for every matched address byte, every received data byte and every transmitted byte. It stays set until a status write with bit 3 equal to 0.
- R9: Reading register 0 returns the buffer and clears full. A status write with bit 1 equal to 0 clears overflow; writing 1 there has no effect.
- R10: During a transmit, an acknowledge from the bus on the ninth clock makes the target stretch SCL again for the next byte. A not-acknowledge releases both lines and leaves the target waiting for STOP or START.
- R11: The own address resets to the parameter `DEF_ADDR` (0x3A by default) and is writable and readable at register 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock, oversamples the bus |
| rst | input | 1 | synchronous active-high reset |
| scl_i | input | 1 | sensed SCL line level |
| sda_i | input | 1 | sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretching) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge or data 0) |
| hst_addr | input | 2 | register index: 0 data, 1 status, 2 own address |
| hst_wr | input | 1 | register write strobe |
| hst_rd | input | 1 | register read strobe |
| hst_wdata | input | 8 | register write data |
| hst_rdata | output | 8 | registered read data, valid the cycle after the strobe |
| irq | output | 1 | byte event flag |

## Verification
The assertions watch four behaviours on every cycle. First, the stretch is held in the waiting state until a release arrives. Second, SDA does not move during a transmit bit except after a falling SCL edge. Third, a byte arriving into a full buffer leaves the buffer untouched and raises overflow, while a byte arriving into an empty buffer is captured intact. Fourth, the event flag stays set until it is cleared. Only the bench scenarios can show the bus-level outcomes: the acknowledge or its absence under each combination of full and overflow, the address match and mismatch, and the release being refused without a transmit byte. They also show the byte order on SDA and the end of a read after a not-acknowledge.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int I2C_AW = 7;
  localparam int I2C_DW = I2C_AW + 1;

  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_OWN  = 2'd2;

  localparam int ST_FULL = 0;
  localparam int ST_OVF  = 1;
  localparam int ST_DIR  = 2;
  localparam int ST_EVT  = 3;
  localparam int ST_REL  = 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_ACK1,
    S_ACK2,
    S_RX,
    S_STALL,
    S_TX,
    S_TACK
  } tgt_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] prev;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], din[g]};
      end
      assign lvl[g] = pipe[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
#(
  parameter int             AW       = I2C_AW,
  parameter logic [AW-1:0]  DEF_ADDR = 7'h3A,
  localparam int            DW       = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    hst_addr,
  input  logic          hst_wr,
  input  logic          hst_rd,
  input  logic [DW-1:0] hst_wdata,
  output logic [DW-1:0] hst_rdata,
  output logic          irq,
  input  logic          cap_i,
  input  logic [DW-1:0] cap_byte_i,
  input  logic          evt_i,
  input  logic          dir_we_i,
  input  logic          dir_val_i,
  input  logic          stalled_i,
  output logic          rx_full_o,
  output logic          ovf_o,
  output logic [AW-1:0] own_addr_o,
  output logic [DW-1:0] tx_byte_o,
  output logic          rel_o
);

  logic [DW-1:0] rx_buf;
  logic          rx_full, ovf, dir, evt, tx_loaded;
  logic [AW-1:0] own_addr;
  logic [DW-1:0] tx_byte;

  logic wr_stat, wr_data, wr_own, rd_data, rel_ok;
  assign wr_stat = hst_wr && (hst_addr == REG_STAT);
  assign wr_data = hst_wr && (hst_addr == REG_DATA);
  assign wr_own  = hst_wr && (hst_addr == REG_OWN);
  assign rd_data = hst_rd && (hst_addr == REG_DATA);
  assign rel_ok  = wr_stat && hst_wdata[ST_REL] && tx_loaded && stalled_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_buf    <= '0;
      rx_full   <= 1'b0;
      ovf       <= 1'b0;
      dir       <= 1'b0;
      evt       <= 1'b0;
      tx_loaded <= 1'b0;
      tx_byte   <= '0;
      own_addr  <= DEF_ADDR;
      rel_o     <= 1'b0;
      hst_rdata <= '0;
    end else begin
      rel_o <= rel_ok;
      // host side first, bus-side events below take priority
      if (rd_data)                     rx_full <= 1'b0;
      if (wr_stat && !hst_wdata[ST_OVF]) ovf   <= 1'b0;
      if (wr_stat && !hst_wdata[ST_EVT]) evt   <= 1'b0;
      if (wr_data) begin
        tx_byte   <= hst_wdata;
        tx_loaded <= 1'b1;
      end
      if (rel_ok)  tx_loaded <= 1'b0;
      if (wr_own)  own_addr  <= hst_wdata[AW-1:0];
      if (cap_i) begin
        if (rx_full) ovf <= 1'b1;
        else begin
          rx_buf  <= cap_byte_i;
          rx_full <= 1'b1;
        end
      end
      if (evt_i)    evt <= 1'b1;
      if (dir_we_i) dir <= dir_val_i;
      if (hst_rd) begin
        case (hst_addr)
          REG_DATA: hst_rdata <= rx_buf;
          REG_STAT: hst_rdata <= DW'({evt, dir, ovf, rx_full});
          REG_OWN:  hst_rdata <= DW'(own_addr);
          default:  hst_rdata <= '0;
        endcase
      end
    end
  end

  assign irq        = evt;
  assign rx_full_o  = rx_full;
  assign ovf_o      = ovf;
  assign own_addr_o = own_addr;
  assign tx_byte_o  = tx_byte;

  AST_OVF_KEEPS_BUF: assert property (@(posedge clk) disable iff (rst)
    (cap_i && rx_full) |=> (ovf && $stable(rx_buf))); // R6
  AST_EMPTY_LOADS: assert property (@(posedge clk) disable iff (rst)
    (cap_i && !rx_full) |=> (rx_full && (rx_buf == $past(cap_byte_i)))); // R5
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (evt && !(wr_stat && !hst_wdata[ST_EVT])) |=> evt); // R8

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int  AW = I2C_AW,
  localparam int DW = AW + 1,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          sda_rise,
  input  logic          sda_fall,
  input  logic [AW-1:0] own_addr,
  input  logic          rx_full,
  input  logic          rx_ovf,
  input  logic [DW-1:0] tx_byte,
  input  logic          rel_i,
  output logic          cap_o,
  output logic [DW-1:0] cap_byte_o,
  output logic          evt_o,
  output logic          dir_we_o,
  output logic          dir_val_o,
  output logic          stalled_o,
  output logic          scl_oe_o,
  output logic          sda_oe_o
);

  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  tgt_state_t    st;
  logic [CW-1:0] cnt;
  logic [DW-2:0] rx_sh;
  logic [DW-1:0] tx_sh;
  logic          ack_pend, rd_pend, addr_ph, mst_ack;
  logic          start_det, stop_det;

  assign start_det = sda_fall && scl_lvl;
  assign stop_det  = sda_rise && scl_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cnt        <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      ack_pend   <= 1'b0;
      rd_pend    <= 1'b0;
      addr_ph    <= 1'b0;
      mst_ack    <= 1'b0;
      scl_oe_o   <= 1'b0;
      sda_oe_o   <= 1'b0;
      cap_o      <= 1'b0;
      cap_byte_o <= '0;
      evt_o      <= 1'b0;
      dir_we_o   <= 1'b0;
      dir_val_o  <= 1'b0;
    end else begin
      cap_o    <= 1'b0;
      evt_o    <= 1'b0;
      dir_we_o <= 1'b0;
      if (start_det) begin
        st       <= S_ADDR;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
        scl_oe_o <= 1'b0;
      end else if (stop_det) begin
        st       <= S_IDLE;
        sda_oe_o <= 1'b0;
        scl_oe_o <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_RX: if (scl_rise) begin
            rx_sh <= {rx_sh[DW-3:0], sda_lvl};
            if (cnt == LAST) begin
              cnt <= '0;
              if (st == S_RX) begin
                cap_o      <= 1'b1;
                cap_byte_o <= {rx_sh, sda_lvl};
                evt_o      <= 1'b1;
                rd_pend    <= 1'b0;
                addr_ph    <= 1'b0;
                ack_pend   <= ~(rx_full | rx_ovf);
                st         <= S_ACK1;
              end else if (rx_sh == own_addr) begin
                cap_o      <= 1'b1;
                cap_byte_o <= {rx_sh, sda_lvl};
                evt_o      <= 1'b1;
                dir_we_o   <= 1'b1;
                dir_val_o  <= sda_lvl;
                rd_pend    <= sda_lvl;
                addr_ph    <= 1'b1;
                ack_pend   <= sda_lvl | ~(rx_full | rx_ovf);
                st         <= S_ACK1;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_ACK1: if (scl_fall) begin
            sda_oe_o <= ack_pend;
            st       <= S_ACK2;
          end
          S_ACK2: if (scl_fall) begin
            sda_oe_o <= 1'b0;
            if (rd_pend && ack_pend) begin
              scl_oe_o <= 1'b1;
              st       <= S_STALL;
            end else if (addr_ph && !ack_pend) begin
              st <= S_IDLE;
            end else begin
              cnt <= '0;
              st  <= S_RX;
            end
          end
          S_STALL: if (rel_i) begin
            scl_oe_o <= 1'b0;
            tx_sh    <= tx_byte;
            sda_oe_o <= ~tx_byte[DW-1];
            cnt      <= '0;
            st       <= S_TX;
          end
          S_TX: if (scl_fall) begin
            if (cnt == LAST) begin
              sda_oe_o <= 1'b0;
              st       <= S_TACK;
            end else begin
              tx_sh    <= {tx_sh[DW-2:0], tx_sh[DW-1]};
              sda_oe_o <= ~tx_sh[DW-2];
              cnt      <= cnt + 1'b1;
            end
          end
          S_TACK: begin
            if (scl_rise) begin
              mst_ack <= ~sda_lvl;
              evt_o   <= 1'b1;
            end
            if (scl_fall) begin
              if (mst_ack) begin
                scl_oe_o <= 1'b1;
                st       <= S_STALL;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign stalled_o = (st == S_STALL);

  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == S_STALL && !rel_i && !start_det && !stop_det) |=> scl_oe_o); // R3
  AST_TX_SDA_STABLE: assert property (@(posedge clk) disable iff (rst)
    (st == S_TX && !scl_fall && !start_det && !stop_det) |=> $stable(sda_oe_o)); // R4

endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch
  import i2c_tgt_pkg::*;
#(
  parameter int            AW          = I2C_AW,
  parameter logic [AW-1:0] DEF_ADDR    = 7'h3A,
  parameter int            SYNC_STAGES = 2,
  localparam int           DW          = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic [1:0]    hst_addr,
  input  logic          hst_wr,
  input  logic          hst_rd,
  input  logic [DW-1:0] hst_wdata,
  output logic [DW-1:0] hst_rdata,
  output logic          irq
);

  logic [1:0]    lvl, rise, fall;
  logic          cap, evt, dir_we, dir_val, stalled, rx_full, ovf, rel;
  logic [DW-1:0] cap_byte, tx_byte;
  logic [AW-1:0] own_addr;

  i2c_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({sda_i, scl_i}),
    .lvl (lvl),
    .rise(rise),
    .fall(fall)
  );

  i2c_tgt_engine #(.AW(AW)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .scl_lvl   (lvl[0]),
    .scl_rise  (rise[0]),
    .scl_fall  (fall[0]),
    .sda_lvl   (lvl[1]),
    .sda_rise  (rise[1]),
    .sda_fall  (fall[1]),
    .own_addr  (own_addr),
    .rx_full   (rx_full),
    .rx_ovf    (ovf),
    .tx_byte   (tx_byte),
    .rel_i     (rel),
    .cap_o     (cap),
    .cap_byte_o(cap_byte),
    .evt_o     (evt),
    .dir_we_o  (dir_we),
    .dir_val_o (dir_val),
    .stalled_o (stalled),
    .scl_oe_o  (scl_oe),
    .sda_oe_o  (sda_oe)
  );

  i2c_tgt_regs #(.AW(AW), .DEF_ADDR(DEF_ADDR)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .hst_addr  (hst_addr),
    .hst_wr    (hst_wr),
    .hst_rd    (hst_rd),
    .hst_wdata (hst_wdata),
    .hst_rdata (hst_rdata),
    .irq       (irq),
    .cap_i     (cap),
    .cap_byte_i(cap_byte),
    .evt_i     (evt),
    .dir_we_i  (dir_we),
    .dir_val_i (dir_val),
    .stalled_i (stalled),
    .rx_full_o (rx_full),
    .ovf_o     (ovf),
    .own_addr_o(own_addr),
    .tx_byte_o (tx_byte),
    .rel_o     (rel)
  );

endmodule

// File: tb/i2c_tgt_stretch_tb_top.sv
module i2c_tgt_stretch_tb_top;

  localparam int Q = 16;

  logic       clk = 1'b0;
  logic       rst;
  logic       scl_m, sda_m;
  logic       scl_oe, sda_oe;
  logic [1:0] hst_addr;
  logic       hst_wr, hst_rd;
  logic [7:0] hst_wdata, hst_rdata;
  logic       irq;
  logic       scl_line, sda_line;
  logic       done = 1'b0;
  int         n_chk = 0;
  int         n_fail = 0;

  always #4 clk = ~clk;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  i2c_tgt_stretch dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .hst_addr(hst_addr), .hst_wr(hst_wr),
    .hst_rd(hst_rd), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic h_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic h_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    hst_addr = a; hst_rd = 1'b1;
    @(negedge clk);
    hst_rd = 1'b0;
    d = hst_rdata;
  endtask

  task automatic scl_high();
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; cyc(Q);
    scl_high(); cyc(Q);
    sda_m = 1'b0; cyc(Q);
    scl_m = 1'b0; cyc(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; cyc(Q);
    scl_high(); cyc(Q);
    sda_m = 1'b1; cyc(Q);
  endtask

  task automatic m_wbit(input logic b);
    sda_m = b; cyc(Q);
    scl_high(); cyc(2 * Q);
    scl_m = 1'b0; cyc(Q);
  endtask

  task automatic m_rbit(output logic b);
    sda_m = 1'b1; cyc(Q);
    scl_high(); cyc(Q);
    b = sda_line; cyc(Q);
    scl_m = 1'b0; cyc(Q);
  endtask

  task automatic m_wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) m_wbit(d[i]);
    m_rbit(b);
    ack = ~b;
  endtask

  task automatic m_rbyte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      m_rbit(b);
      d[i] = b;
    end
    m_wbit(~give_ack);
  endtask

  task automatic clean();
    logic [7:0] d;
    h_read(2'd0, d);
    h_write(2'd1, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 scl_oe after reset", scl_oe, 0);
    chk("R1 sda_oe after reset", sda_oe, 0);
    chk("R1 irq after reset", irq, 0);
    h_read(2'd1, d);
    chk("R1 status after reset", d, 8'h00);
    h_read(2'd2, d);
    chk("R11 default own address", d, 8'h3A);
    h_write(2'd2, 8'h52);
    h_read(2'd2, d);
    chk("R11 own address write", d, 8'h52);
  endtask

  task automatic t_write();
    logic ack;
    logic [7:0] d;
    clean();
    m_start();
    m_wbyte(8'hA4, ack);
    chk("R2 write address ack", ack, 1);
    chk("R8 irq after address", irq, 1);
    h_read(2'd1, d);
    chk("R2 status full dir0 evt", d, 8'h09);
    cyc(50);
    chk("R8 irq stays set", irq, 1);
    h_read(2'd0, d);
    chk("R2 buffer holds address byte", d, 8'hA4);
    h_read(2'd1, d);
    chk("R9 read clears full", d, 8'h08);
    h_write(2'd1, 8'h00);
    chk("R8 irq cleared by write 0", irq, 0);
    m_wbyte(8'h5C, ack);
    chk("R5 data ack", ack, 1);
    h_read(2'd0, d);
    chk("R5 data captured", d, 8'h5C);
    m_stop();
    cyc(8);
    chk("R1 scl released after stop", scl_oe, 0);
    chk("R1 sda released after stop", sda_oe, 0);
  endtask

  task automatic t_nomatch();
    logic ack;
    logic [7:0] d;
    clean();
    m_start();
    m_wbyte(8'h22, ack);
    chk("R2 mismatch no ack", ack, 0);
    chk("R2 mismatch no event", irq, 0);
    m_wbyte(8'h66, ack);
    chk("R2 ignored until START", ack, 0);
    h_read(2'd1, d);
    chk("R2 mismatch status untouched", d, 8'h00);
    m_stop();
  endtask

  task automatic t_overflow();
    logic ack;
    logic [7:0] d;
    clean();
    m_start();
    m_wbyte(8'hA4, ack);
    chk("R2 address ack before overflow", ack, 1);
    m_wbyte(8'h33, ack);
    chk("R6 no ack when full", ack, 0);
    h_read(2'd1, d);
    chk("R6 overflow flag set", d, 8'h0B);
    h_read(2'd0, d);
    chk("R6 buffer kept old byte", d, 8'hA4);
    m_wbyte(8'h77, ack);
    chk("R7 no ack while overflow", ack, 0);
    h_read(2'd0, d);
    chk("R7 byte loaded despite overflow", d, 8'h77);
    h_write(2'd1, 8'h0A);
    h_read(2'd1, d);
    chk("R9 writing 1 keeps overflow", d, 8'h0A);
    h_write(2'd1, 8'h00);
    m_wbyte(8'h99, ack);
    chk("R9 ack after overflow cleared", ack, 1);
    m_stop();
    h_read(2'd0, d);
    chk("R5 byte after clear", d, 8'h99);
    h_read(2'd1, d);
    chk("R9 status after clear", d, 8'h08);
  endtask

  task automatic t_read();
    logic ack;
    logic [7:0] d;
    clean();
    m_start();
    m_wbyte(8'hA5, ack);
    chk("R3 read address ack", ack, 1);
    cyc(Q);
    chk("R3 scl stretched", scl_oe, 1);
    h_read(2'd1, d);
    chk("R3 status dir1", d, 8'h0D);
    h_read(2'd0, d);
    chk("R3 buffer holds read address", d, 8'hA5);
    h_write(2'd1, 8'h10);
    cyc(20);
    chk("R3 release refused without tx byte", scl_oe, 1);
    h_write(2'd0, 8'hC5);
    h_write(2'd1, 8'h10);
    cyc(10);
    chk("R3 scl released", scl_oe, 0);
    m_rbyte(1'b1, d);
    chk("R4 first byte MSB first", d, 8'hC5);
    chk("R10 stretch after host ack", scl_oe, 1);
    chk("R8 irq after transmitted byte", irq, 1);
    h_write(2'd0, 8'h3A);
    h_write(2'd1, 8'h10);
    m_rbyte(1'b0, d);
    chk("R4 second byte", d, 8'h3A);
    chk("R10 no stretch after nack", scl_oe, 0);
    chk("R10 sda released after nack", sda_oe, 0);
    m_stop();
  endtask

  initial begin
    rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
    hst_addr = 2'd0; hst_wr = 1'b0; hst_rd = 1'b0; hst_wdata = 8'h00;
    cyc(5);
    rst = 1'b0;
    cyc(5);
    t_reset();
    t_write();
    t_nomatch();
    t_overflow();
    t_read();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule